// File: doc/BRIEF.md
# Register File with Pointer Pair

This block holds the working registers of a small RISC core: thirty-two 8-bit registers with two combinational read ports and one write port. Each port carries a register number together with a 2-bit addressing mode. The mode lets the same port serve three kinds of access. Register-to-register operations can reach the whole file. Operations with a constant carry only a 4-bit register field, which reaches the upper half of the file. Indirect accesses take the register number from the low byte of the pointer pair.

The two highest registers also form a 16-bit pointer. The high byte sits in register 31 and the low byte in register 30. The pointer is driven out of the block at all times, so a memory address path can use it without taking a read port. A separate 16-bit pointer write port loads both bytes on a single clock edge. The instruction decoder drives all ports of the block.

Top module: `ptr_regfile`

## Requirements
- R1: Both read ports return, without a clock, the content of the selected register. In direct mode (mode code 2'b00, and also 2'b11) the register number is the full 5-bit port address, 0 through 31.
- R2: With `wr_en` high, the selected register takes `wr_data` on the rising clock edge. Direct mode on the write port reaches any of the 32 registers.
- R3: A read of a register that is being written in the same cycle returns the value it held before the edge.
- R4: In upper mode (mode code 2'b01) the register number is 16 plus address bits [3:0]. Address bit 4 is ignored. This applies to both read ports and to the write port.
- R5: In indirect mode (mode code 2'b10) the register number is bits [4:0] of register 30. The port address, bits [7:5] of register 30 and all of register 31 have no effect on which register is selected.
- R6: `ptr` always equals {register 31, register 30}.
- R7: With `ptr_wr_en` high, register 30 takes `ptr_wr_data[7:0]` and register 31 takes `ptr_wr_data[15:8]` on the same edge.
- R8: When a byte write and a pointer write hit register 30 or 31 in the same cycle, the pointer write wins. A byte write to any other register in that cycle still takes effect.
- R9: Asserting `rst_n` low clears all registers to zero at once. After `rst_n` rises, the block stays in reset through two more rising edges, and writes during that time are ignored.
- R10: An indirect write uses the value register 30 held before the edge, even when a pointer write changes register 30 on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_mode | input | 2 | Addressing mode of read port A |
| rd_a_addr | input | 5 | Register number or 4-bit field of read port A |
| rd_a_data | output | 8 | Read data, port A |
| rd_b_mode | input | 2 | Addressing mode of read port B |
| rd_b_addr | input | 5 | Register number or 4-bit field of read port B |
| rd_b_data | output | 8 | Read data, port B |
| wr_en | input | 1 | Byte write enable |
| wr_mode | input | 2 | Addressing mode of the write port |
| wr_addr | input | 5 | Register number or 4-bit field of the write port |
| wr_data | input | 8 | Byte write data |
| ptr_wr_en | input | 1 | Pointer pair write enable |
| ptr_wr_data | input | 16 | New pointer value, high byte to register 31 |
| ptr | output | 16 | Current pointer {register 31, register 30} |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge once reset is released, including all four mode codes. They also assume that `rst_n` alone is the source of reset. The bench changes inputs only on falling edges and draws every mode code, address and data value from the full range, so this assumption holds. Resets in the middle of a run are applied with the write ports still active, and the bench waits out the two-edge release before it relies on stored values.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT   = 2'b00,
    AM_UPPER    = 2'b01,
    AM_INDIRECT = 2'b10,
    AM_DIRECT2  = 2'b11
  } amode_e;
endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/rf_addr_map.sv
module rf_addr_map
  import regfile_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] ptr_lo_i,
  output logic [ADDR_W-1:0] idx_o
);
  amode_e mode;
  assign mode = amode_e'(mode_i);

  always_comb begin
    unique case (mode)
      AM_UPPER:    idx_o = {1'b1, addr_i[ADDR_W-2:0]};
      AM_INDIRECT: idx_o = ptr_lo_i[ADDR_W-1:0];
      default:     idx_o = addr_i;
    endcase
  end
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import regfile_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            rd_a_mode,
  input  logic [4:0]            rd_a_addr,
  output logic [DATA_W-1:0]     rd_a_data,
  input  logic [1:0]            rd_b_mode,
  input  logic [4:0]            rd_b_addr,
  output logic [DATA_W-1:0]     rd_b_data,
  input  logic                  wr_en,
  input  logic [1:0]            wr_mode,
  input  logic [4:0]            wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  ptr_wr_en,
  input  logic [2*DATA_W-1:0]   ptr_wr_data,
  output logic [2*DATA_W-1:0]   ptr
);
  localparam int ADDR_W = $clog2(NREG);
  localparam int PTR_LO = NREG - 2;
  localparam int PTR_HI = NREG - 1;

  logic              rst_int_n;
  logic [DATA_W-1:0] regs [NREG];
  logic [ADDR_W-1:0] ra_idx, rb_idx, w_idx;

  rf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  rf_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map_a (
    .mode_i(rd_a_mode), .addr_i(rd_a_addr), .ptr_lo_i(regs[PTR_LO]), .idx_o(ra_idx)
  );
  rf_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map_b (
    .mode_i(rd_b_mode), .addr_i(rd_b_addr), .ptr_lo_i(regs[PTR_LO]), .idx_o(rb_idx)
  );
  rf_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map_w (
    .mode_i(wr_mode), .addr_i(wr_addr), .ptr_lo_i(regs[PTR_LO]), .idx_o(w_idx)
  );

  // Storage: one enabled register per entry, pointer write overrides byte write
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              en;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q;

    always_comb begin
      en = 1'b0;
      d  = q;
      if (wr_en && (w_idx == ADDR_W'(i))) begin
        en = 1'b1;
        d  = wr_data;
      end
      if (ptr_wr_en && (i == PTR_LO)) begin
        en = 1'b1;
        d  = ptr_wr_data[DATA_W-1:0];
      end
      if (ptr_wr_en && (i == PTR_HI)) begin
        en = 1'b1;
        d  = ptr_wr_data[2*DATA_W-1:DATA_W];
      end
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) q <= '0;
      else if (en)    q <= d;
    end

    assign regs[i] = q;
  end

  assign rd_a_data = regs[ra_idx];
  assign rd_b_data = regs[rb_idx];
  assign ptr       = {regs[PTR_HI], regs[PTR_LO]};

  // R2
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !(ptr_wr_en && (w_idx >= ADDR_W'(PTR_LO)))) |=> regs[$past(w_idx)] == $past(wr_data));
  // R4
  upper_half_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_a_mode == AM_UPPER) |-> (ra_idx >= ADDR_W'(NREG/2)) && (ra_idx[ADDR_W-2:0] == rd_a_addr[ADDR_W-2:0]));
  // R5
  indirect_rd_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_b_mode == AM_INDIRECT) |-> rd_b_data == regs[regs[PTR_LO][ADDR_W-1:0]]);
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_en && !ptr_wr_en) |=> $stable(ptr));
  // R7
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ptr_wr_en |=> ptr == $past(ptr_wr_data));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_int_n |-> (ptr == '0) && (rd_a_data == '0) && (rd_b_data == '0));
endmodule

// File: tb/ptr_regfile_tb.sv
`timescale 1ns/1ps
module ptr_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  rd_a_mode, rd_b_mode, wr_mode;
  logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [7:0]  rd_a_data, rd_b_data, wr_data;
  logic        wr_en, ptr_wr_en;
  logic [15:0] ptr_wr_data, ptr;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m [32];

  always #4 clk = ~clk;

  ptr_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_mode(rd_a_mode), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_mode(rd_b_mode), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data), .ptr(ptr)
  );

  function automatic int ref_idx(logic [1:0] mode, logic [4:0] addr);
    case (mode)
      2'b01:   return 16 + int'(addr[3:0]);
      2'b10:   return int'(m[30][4:0]);
      default: return int'(addr);
    endcase
  endfunction

  function automatic string mode_tag(logic [1:0] mode);
    case (mode)
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; ptr_wr_en = 0; wr_mode = 0; wr_addr = 0; wr_data = 0;
    ptr_wr_data = 0; rd_a_mode = 0; rd_a_addr = 0; rd_b_mode = 0; rd_b_addr = 0;
  endtask

  task automatic clear_model();
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
  endtask

  // compare outputs, then advance one edge and update the model
  task automatic step();
    int wi;
    #1;
    chk(mode_tag(rd_a_mode), {8'h00, rd_a_data}, {8'h00, m[ref_idx(rd_a_mode, rd_a_addr)]});
    chk(mode_tag(rd_b_mode), {8'h00, rd_b_data}, {8'h00, m[ref_idx(rd_b_mode, rd_b_addr)]});
    chk("R6", ptr, {m[31], m[30]});
    wi = ref_idx(wr_mode, wr_addr);
    @(posedge clk);
    if (wr_en) m[wi] = wr_data;
    if (ptr_wr_en) begin
      m[30] = ptr_wr_data[7:0];
      m[31] = ptr_wr_data[15:8];
    end
    @(negedge clk);
  endtask

  task automatic rd_direct(int r, string tag, logic [7:0] exp);
    rd_a_mode = 2'b00; rd_a_addr = 5'(r);
    #1 chk(tag, {8'h00, rd_a_data}, {8'h00, exp});
  endtask

  task automatic do_reset();
    rst_n = 0;
    #1 chk("R9", ptr, 16'h0000);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);   // write still held off during release
    wr_en = 0; ptr_wr_en = 0;
    repeat (2) @(negedge clk);
    clear_model();
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9 reset state
    for (int i = 0; i < 32; i++) rd_direct(i, "R9", 8'h00);

    // R2 direct write, R3 read-old during write
    wr_en = 1; wr_mode = 2'b00; wr_addr = 5; wr_data = 8'hA5;
    step();
    wr_data = 8'h3C; rd_a_mode = 2'b00; rd_a_addr = 5;
    #1 chk("R3", {8'h00, rd_a_data}, 16'h00A5);
    step();
    wr_en = 0;
    rd_direct(5, "R2", 8'h3C);

    // R4 upper mode write with bit 4 clear
    wr_en = 1; wr_mode = 2'b01; wr_addr = 5'b00011; wr_data = 8'h77;
    step();
    wr_en = 0;
    rd_direct(19, "R4", 8'h77);
    rd_direct(3, "R4", 8'h00);

    // R7 pointer write
    ptr_wr_en = 1; ptr_wr_data = 16'h1234;
    step();
    ptr_wr_en = 0;
    rd_direct(30, "R7", 8'h34);
    rd_direct(31, "R7", 8'h12);

    // R5 indirect read ignores R30[7:5], R31 and port address
    wr_en = 1; wr_mode = 2'b00; wr_addr = 30; wr_data = 8'hE7;
    step();
    wr_addr = 7; wr_data = 8'h99;
    step();
    wr_en = 0;
    rd_a_mode = 2'b10; rd_a_addr = 5'd12;
    #1 chk("R5", {8'h00, rd_a_data}, 16'h0099);

    // R10 indirect write with concurrent pointer change
    wr_en = 1; wr_mode = 2'b10; wr_addr = 0; wr_data = 8'h5A;
    ptr_wr_en = 1; ptr_wr_data = 16'hFF08;
    step();
    wr_en = 0; ptr_wr_en = 0;
    rd_direct(7, "R10", 8'h5A);
    rd_direct(8, "R10", 8'h00);
    #1 chk("R7", ptr, 16'hFF08);

    // R8 pointer wins on R30, byte write elsewhere still lands
    wr_en = 1; wr_mode = 2'b00; wr_addr = 30; wr_data = 8'h11;
    ptr_wr_en = 1; ptr_wr_data = 16'hABCD;
    step();
    wr_addr = 2; wr_data = 8'h22; ptr_wr_data = 16'h4321;
    step();
    wr_en = 0; ptr_wr_en = 0;
    #1 chk("R8", ptr, 16'h4321);
    rd_direct(2, "R8", 8'h22);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      rd_a_mode = 2'($urandom); rd_a_addr = 5'($urandom);
      rd_b_mode = 2'($urandom); rd_b_addr = 5'($urandom);
      wr_en = ($urandom % 3) != 0; wr_mode = 2'($urandom);
      wr_addr = 5'($urandom); wr_data = 8'($urandom);
      ptr_wr_en = ($urandom % 8) == 0; ptr_wr_data = 16'($urandom);
      step();
    end

    // R9 mid-run reset with writes held active
    wr_en = 1; wr_mode = 2'b00; wr_addr = 9; wr_data = 8'hC3;
    ptr_wr_en = 1; ptr_wr_data = 16'h7777;
    do_reset();
    idle_inputs();
    rd_direct(9, "R9", 8'h00);
    #1 chk("R9", ptr, 16'h0000);
    for (int n = 0; n < 200; n++) begin
      rd_a_mode = 2'($urandom); rd_a_addr = 5'($urandom);
      rd_b_mode = 2'($urandom); rd_b_addr = 5'($urandom);
      wr_en = $urandom % 2 == 1; wr_mode = 2'($urandom);
      wr_addr = 5'($urandom); wr_data = 8'($urandom);
      ptr_wr_en = ($urandom % 6) == 0; ptr_wr_data = 16'($urandom);
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule